// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block decides who drives an external memory bus: the local bus engine, or an outside device that asks for the bus by pulling an active-low hold request. The request is passed through a two-stage synchronizer on the interface timing clock. Once the synchronized request is seen low, the arbiter stops launching new accesses and waits until the engine reports that no access is in flight. It then removes the output enables for the address, data and control pins. One cycle later it drives the active-low hold acknowledge low. When the request returns high, it raises the acknowledge first and re-enables the pins one cycle after that.

Local access requests enter through a valid/ready stream and wait in a small in-order queue. The queue forwards them to the engine through a second valid/ready stream. A request is accepted whenever the queue has room, including while the bus is held. The upstream side must keep `in_valid` and `in_data` stable until `in_ready` is high. Nothing leaves the queue unless the local side owns the bus, and the engine side may hold back with `eng_ready`. The engine must raise `eng_busy` in the cycle after it accepts a launch and keep it high until that access has finished on the pins. `stall` tells the local master that the bus is not currently its own.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset `hold_ack_n` is 1, `addr_oe`, `data_oe` and `ctrl_oe` are 1, `stall` is 0 and `in_ready` is 1.
- R2: `hold_req_n` is sampled only at rising clock edges: a low pulse that starts after one rising edge and ends before the next changes no output.
- R3: With `eng_busy` low and the queue empty, the three output enables go to 0 right after the 4th rising edge that samples `hold_req_n` low, and `hold_ack_n` goes to 0 right after the 5th.
- R4: While an access is in flight (`eng_busy` high), the enables stay 1 and `hold_ack_n` stays 1. If `eng_busy` is high through edge b, the enables drop after edge max(4, b+1) and the acknowledge falls one edge later.
- R5: `hold_ack_n` is 0 only while all three enables are 0, and it falls only after the enables were already 0 in the previous cycle.
- R6: Counting from the first rising edge that samples `hold_req_n` high during a grant, `hold_ack_n` returns to 1 after the 3rd edge and the enables return to 1 after the 4th. The acknowledge is therefore high for at least one cycle before the pins are driven again.
- R7: `eng_valid` is 0 whenever the enables are 0 or `stall` is 1. `stall` is 1 from the cycle the arbiter starts draining until bus ownership is restored.
- R8: Requests accepted while the bus is held are neither dropped nor reordered. They are offered on `eng_data` in arrival order once the enables are back on.
- R9: If the request returns high while the arbiter is still draining, it goes back to owning the bus without ever driving `hold_ack_n` low or dropping the enables.
- R10: If `hold_req_n` is already low when reset is released, the normal drain-then-grant timing of R3 applies from the first edge after reset.
- R11: With QUEUE_DEPTH entries waiting, `in_ready` is 0 and no further request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold_req_n | input | 1 | Active-low bus hold request from the outside device |
| eng_busy | input | 1 | High while the local engine has an external access in flight |
| in_valid | input | 1 | Local access request valid |
| in_ready | output | 1 | Queue can take a request |
| in_data | input | DATA_W | Local access descriptor |
| eng_valid | output | 1 | Queued request offered to the engine |
| eng_ready | input | 1 | Engine accepts the offered request |
| eng_data | output | DATA_W | Descriptor offered to the engine |
| addr_oe | output | 1 | Output enable for address pins |
| data_oe | output | 1 | Output enable for data pins |
| ctrl_oe | output | 1 | Output enable for strobe and chip-select pins |
| hold_ack_n | output | 1 | Active-low hold acknowledge |
| stall | output | 1 | Local master is not the bus owner |

## Verification
The bench sweeps the number of cycles an access stays in flight and checks that the enables drop exactly at max(4, b+1) edges. A design that ignored `eng_busy` would float a bus mid-access, and one that waited an extra cycle would break the budget. It also sweeps the moment the request is withdrawn during draining. A wrong design there would pulse the acknowledge or float the pins for a hold nobody wants. Release ordering is checked edge by edge, so re-enabling the pins before raising the acknowledge would show up as a contention window. The last part of the bench queues requests during a hold, which exposes launches while the bus is granted, lost entries and reordering.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [2:0] {
    HS_OWN     = 3'd0,
    HS_DRAIN   = 3'd1,
    HS_FLOAT   = 3'd2,
    HS_GRANT   = 3'd3,
    HS_RELEASE = 3'd4
  } hold_state_e;
endpackage

// File: rtl/bus_hold_sync.sv
module bus_hold_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= RESET_VAL;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bus_hold_queue.sv
module bus_hold_queue #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R11
  AST_QUEUE_NO_PHANTOM_POP: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
  AST_QUEUE_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R11
endmodule

// File: rtl/bus_hold_fsm.sv
module bus_hold_fsm
  import bus_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s_n,
  input  logic eng_busy,
  input  logic launch,
  output logic oe,
  output logic ack_n,
  output logic own
);
  hold_state_e state, state_d;
  logic        oe_q, ack_n_q, launch_q;

  always_comb begin
    state_d = state;
    unique case (state)
      HS_OWN:     if (!req_s_n) state_d = HS_DRAIN;
      HS_DRAIN: begin
        if (req_s_n)                     state_d = HS_OWN;
        else if (!eng_busy && !launch_q) state_d = HS_FLOAT;
      end
      HS_FLOAT:   state_d = HS_GRANT;
      HS_GRANT:   if (req_s_n) state_d = HS_RELEASE;
      HS_RELEASE: state_d = HS_OWN;
      default:    state_d = HS_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= HS_OWN;
      oe_q     <= 1'b1;
      ack_n_q  <= 1'b1;
      launch_q <= 1'b0;
    end else begin
      state    <= state_d;
      oe_q     <= (state_d == HS_OWN) || (state_d == HS_DRAIN);
      ack_n_q  <= (state_d != HS_GRANT);
      launch_q <= launch;
    end
  end

  assign oe    = oe_q;
  assign ack_n = ack_n_q;
  assign own   = (state == HS_OWN);

  AST_ACK_ONLY_FLOATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_q |-> !oe_q); // R5
  AST_ACK_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n_q) |-> !$past(oe_q)); // R5
  AST_GAP_BEFORE_REDRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(ack_n_q)); // R6
  AST_RELEASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_GRANT && req_s_n) |=> (ack_n_q && !oe_q)); // R6
  AST_ABORT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_DRAIN && req_s_n) |=> (state == HS_OWN && ack_n_q && oe_q)); // R9
  AST_DRAIN_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_DRAIN && eng_busy) |=> oe_q); // R4
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
  parameter int DATA_W      = 16,
  parameter int QUEUE_DEPTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req_n,
  input  logic              eng_busy,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [DATA_W-1:0] eng_data,
  output logic              addr_oe,
  output logic              data_oe,
  output logic              ctrl_oe,
  output logic              hold_ack_n,
  output logic              stall
);
  logic req_s_n;
  logic q_full, q_empty;
  logic push, pop;
  logic own, oe;

  bus_hold_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (hold_req_n),
    .dout (req_s_n)
  );

  assign in_ready  = !q_full;
  assign push      = in_valid && in_ready;
  assign eng_valid = !q_empty && own;
  assign pop       = eng_valid && eng_ready;

  bus_hold_queue #(.W(DATA_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(in_data),
    .full     (q_full),
    .pop      (pop),
    .pop_data (eng_data),
    .empty    (q_empty)
  );

  bus_hold_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_s_n (req_s_n),
    .eng_busy(eng_busy),
    .launch  (pop),
    .oe      (oe),
    .ack_n   (hold_ack_n),
    .own     (own)
  );

  assign addr_oe = oe;
  assign data_oe = oe;
  assign ctrl_oe = oe;
  assign stall   = !own;

  AST_NO_LAUNCH_FLOATED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> (addr_oe && !stall)); // R7
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !in_ready); // R11
endmodule

// File: tb/tb_bus_hold_arbiter.sv
module tb_bus_hold_arbiter;
  localparam int DW = 8;
  localparam int QD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_req_n = 1'b1, eng_busy = 1'b0, in_valid = 1'b0, eng_ready = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, eng_valid, addr_oe, data_oe, ctrl_oe, hold_ack_n, stall;
  logic [DW-1:0] eng_data;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bus_hold_arbiter #(.DATA_W(DW), .QUEUE_DEPTH(QD), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .hold_req_n(hold_req_n), .eng_busy(eng_busy),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_data(eng_data),
    .addr_oe(addr_oe), .data_oe(data_oe), .ctrl_oe(ctrl_oe),
    .hold_ack_n(hold_ack_n), .stall(stall)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit all_oe();
    return addr_oe && data_oe && ctrl_oe;
  endfunction

  function automatic bit none_oe();
    return !addr_oe && !data_oe && !ctrl_oe;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset(input logic req_at_release);
    @(negedge clk);
    rst_n = 1'b0; hold_req_n = req_at_release; eng_busy = 1'b0;
    in_valid = 1'b0; eng_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Measures edges to float and to acknowledge after the request falls
  task automatic grant_and_release(input int b);
    int fl, ak, ar, orr;
    bit r5ok;
    fl = 0; ak = 0; r5ok = 1'b1;
    @(negedge clk);
    hold_req_n = 1'b0; eng_busy = (b > 0);
    for (int n = 1; n <= 14; n++) begin
      step();
      if (fl == 0 && none_oe()) fl = n;
      if (ak == 0 && !hold_ack_n) ak = n;
      if (!hold_ack_n && !none_oe()) r5ok = 1'b0;
      if (n == b) eng_busy = 1'b0;
    end
    if (b == 0) check(fl == 4, "R3 float edge", fl, 4);
    else        check(fl == ((b + 1 > 4) ? b + 1 : 4), "R4 float edge", fl, (b + 1 > 4) ? b + 1 : 4);
    check(ak == fl + 1, "R3 R4 ack edge", ak, fl + 1);
    check(r5ok, "R5 ack only while floated", r5ok, 1);
    check(stall == 1'b1, "R7 stall while held", stall, 1);
    ar = 0; orr = 0;
    @(negedge clk);
    hold_req_n = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      step();
      if (ar == 0 && hold_ack_n) ar = n;
      if (orr == 0 && all_oe()) orr = n;
    end
    check(ar == 3, "R6 ack release edge", ar, 3);
    check(orr == 4, "R6 bus valid edge", orr, 4);
    check(stall == 1'b0, "R7 stall cleared", stall, 0);
  endtask

  task automatic abort_case(input int w);
    bit bad, saw;
    bad = 1'b0; saw = 1'b0;
    @(negedge clk);
    hold_req_n = 1'b0; eng_busy = 1'b1;
    for (int n = 1; n <= 12; n++) begin
      step();
      if (!hold_ack_n || !all_oe()) bad = 1'b1;
      if (stall) saw = 1'b1;
      if (n == w) hold_req_n = 1'b1;
    end
    eng_busy = 1'b0;
    step();
    check(!bad, "R9 no grant on abort", bad, 0);
    check(saw, "R9 drain entered", saw, 1);
    check(stall == 1'b0, "R9 ownership back", stall, 0);
  endtask

  initial begin
    int fl, ak, got, exp_k;
    bit bad;

    do_reset(1'b1);
    step();
    check(hold_ack_n == 1'b1, "R1 ack after reset", hold_ack_n, 1);
    check(all_oe(), "R1 enables after reset", all_oe(), 1);
    check(stall == 1'b0, "R1 stall after reset", stall, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    // R2: sub-cycle glitch between edges
    @(negedge clk); #2 hold_req_n = 1'b0; #4 hold_req_n = 1'b1;
    bad = 1'b0;
    for (int n = 0; n < 8; n++) begin
      step();
      if (!hold_ack_n || !all_oe() || stall) bad = 1'b1;
    end
    check(!bad, "R2 glitch ignored", bad, 0);

    for (int b = 0; b <= 7; b++) grant_and_release(b);
    for (int w = 1; w <= 6; w++) abort_case(w);

    // R10: request already low at reset release
    do_reset(1'b0);
    fl = 0; ak = 0;
    for (int n = 1; n <= 8; n++) begin
      step();
      if (fl == 0 && none_oe()) fl = n;
      if (ak == 0 && !hold_ack_n) ak = n;
    end
    check(fl == 4, "R10 float edge", fl, 4);
    check(ak == 5, "R10 ack edge", ak, 5);

    // R8 R11: queue while held, drain in order after release
    bad = 1'b0;
    for (int k = 0; k < QD; k++) begin
      @(negedge clk);
      check(in_ready == 1'b1, "R8 accept while held", in_ready, 1);
      in_valid = 1'b1; in_data = DW'(8'h30 + k);
      step();
      if (eng_valid) bad = 1'b1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R11 full blocks", in_ready, 0);
    check(!bad, "R7 no launch while held", bad, 0);
    eng_ready = 1'b1;
    hold_req_n = 1'b1;
    got = 0; exp_k = 0; bad = 1'b0;
    for (int n = 1; n <= 14; n++) begin
      step();
      if (eng_valid) begin
        if (!all_oe()) bad = 1'b1;
        check(eng_data == DW'(8'h30 + exp_k), "R8 order", eng_data, 8'h30 + exp_k);
        exp_k++; got++;
      end
    end
    check(got == QD, "R8 none lost", got, QD);
    check(!bad, "R7 launch only when driven", bad, 0);
    check(in_ready == 1'b1, "R11 room again", in_ready, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule